// File: doc/BRIEF.md
# Thermometer-to-Binary Mux-Tree Decoder

This block turns the 63-wire thermometer word from a 6-bit flash comparator bank into a 6-bit binary count. Wire 0 is the lowest threshold. The block does not count the ones. It decodes one bit at a time, from the most significant bit down.

The top bit is the middle wire of the full scale. That bit then drives the select of a column of 2:1 multiplexers. The column keeps the upper half of the scale when the bit is 1 and the lower half when it is 0. The next bit is the middle wire of the half that was kept. This repeats until one wire is left, and that wire is the least significant bit.

Before decoding, the input word passes through a parameterised chain of flip-flops that contains comparator metastability. The multiplexer columns can also be separated by registers. In that mode, the bits already decoded travel alongside the data, so that all six output bits leave together.

A valid strobe travels with each sample. The output register loads only when a valid sample reaches it.

Top module: `therm_mux_decoder`

## Requirements
- R1: While reset is high, and after it until the first valid sample emerges, `bin_vld_o` is 0 and `bin_o` is 0.
- R2: For a monotonic input with k wires set (wires 0..k-1 high, k from 0 to 63), the output is k. All-zero gives 0 and all-ones gives 63.
- R3: Output bit 5 equals input wire 31 of the same sample, for any input pattern.
- R4: For a non-monotonic input, the output equals the halving procedure. Start with the full 63-wire scale. Take the middle wire (index w/2 of a width-w scale) as the current bit. Keep the wires above it if that bit is 1, or the wires below it if it is 0. Repeat for the next lower bit. No error is flagged.
- R5: `bin_vld_o` pulses exactly LAT cycles after the `therm_vld_i` cycle that captured the sample. LAT is SYNC_DEPTH + 1, plus NBITS-2 when column registers are enabled.
- R6: While `bin_vld_o` is 0, `bin_o` holds its last value. This holds whatever is driven on `therm_i` during invalid cycles.
- R7: Samples presented on consecutive cycles each produce a result, in order, one per cycle.
- R8: The registered-column and combinational-column variants produce identical values for the same sample stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| therm_i | input | 63 | Thermometer word, wire 0 is the lowest threshold |
| therm_vld_i | input | 1 | Input sample valid |
| bin_o | output | 6 | Decoded binary value |
| bin_vld_o | output | 1 | Output valid |

## Verification
The bench builds two copies of the decoder. One uses a two-stage synchronizer with registered columns, which gives a latency of 7. The other uses a single-stage synchronizer with combinational columns, which gives a latency of 2. Because the width stays at six bits, all 64 monotonic codes can be swept back to back through both copies. Gapped streams of random and single-bubble words then exercise the halving rule. The same gaps, with scrambled input on the invalid cycles, show the output holding.

// File: rtl/tdec_pkg.sv
package tdec_pkg;

    localparam int unsigned TDEC_BITS_DEF = 6;

    typedef enum logic {
        COL_COMB = 1'b0,
        COL_REG  = 1'b1
    } col_mode_e;

    // number of comparator wires for an n-bit code
    function automatic int unsigned therm_levels(input int unsigned n);
        return (1 << n) - 1;
    endfunction

    // width of the partial scale entering decode step q
    function automatic int unsigned step_width(input int unsigned n, input int unsigned q);
        return (1 << (n - q)) - 1;
    endfunction

    // total latency from captured sample to output valid
    function automatic int unsigned dec_latency(input int unsigned n,
                                                input int unsigned sync_depth,
                                                input col_mode_e mode);
        return sync_depth + 1 + ((mode == COL_REG) ? (n - 2) : 0);
    endfunction

endpackage

// File: rtl/tdec_sync.sv
module tdec_sync #(
    parameter int unsigned WIDTH = 63,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic             v_i,
    output logic [WIDTH-1:0] d_o,
    output logic             v_o
);

    logic [WIDTH-1:0] stage_d [DEPTH];
    logic             stage_v [DEPTH];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                stage_d[i] <= '0;
                stage_v[i] <= 1'b0;
            end
        end else begin
            stage_d[0] <= d_i;
            stage_v[0] <= v_i;
            for (int i = 1; i < int'(DEPTH); i++) begin
                stage_d[i] <= stage_d[i-1];
                stage_v[i] <= stage_v[i-1];
            end
        end
    end

    assign d_o = stage_d[DEPTH-1];
    assign v_o = stage_v[DEPTH-1];

endmodule

// File: rtl/tdec_column.sv
module tdec_column #(
    parameter int unsigned W = 63
) (
    input  logic [W-1:0]     scale_i,
    output logic             bit_o,
    output logic [W/2-1:0]   sub_o
);

    localparam int unsigned HALF = W / 2;

    // middle wire of the current partial scale
    assign bit_o = scale_i[HALF];

    // one 2:1 mux per remaining wire, steered by the bit just found
    always_comb begin
        for (int i = 0; i < int'(HALF); i++) begin
            sub_o[i] = bit_o ? scale_i[HALF + 1 + i] : scale_i[i];
        end
    end

    always_comb begin
        if (((scale_i + 1'b1) & scale_i) == '0) begin
            // R2
            therm_keep_chk: assert (((sub_o + 1'b1) & sub_o) == '0);
            // R3
            msb_half_chk: assert (!bit_o || (&scale_i[HALF-1:0]));
        end
        if (scale_i == '0) begin
            // R2
            zero_flow_chk: assert (!bit_o && (sub_o == '0));
        end
    end

endmodule

// File: rtl/therm_mux_decoder.sv
module therm_mux_decoder #(
    parameter int unsigned         NBITS      = tdec_pkg::TDEC_BITS_DEF,
    parameter int unsigned         SYNC_DEPTH = 2,
    parameter tdec_pkg::col_mode_e COL_MODE   = tdec_pkg::COL_REG
) (
    input  logic                                   clk_i,
    input  logic                                   rst_i,
    input  logic [tdec_pkg::therm_levels(NBITS)-1:0] therm_i,
    input  logic                                   therm_vld_i,
    output logic [NBITS-1:0]                       bin_o,
    output logic                                   bin_vld_o
);

    localparam int unsigned LEVELS = tdec_pkg::therm_levels(NBITS);
    localparam int unsigned LAT    = tdec_pkg::dec_latency(NBITS, SYNC_DEPTH, COL_MODE);
    localparam int unsigned NSTEP  = NBITS - 1;

    logic [LEVELS-1:0] sync_d;
    logic              sync_v;

    tdec_sync #(
        .WIDTH (LEVELS),
        .DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (therm_i),
        .v_i   (therm_vld_i),
        .d_o   (sync_d),
        .v_o   (sync_v)
    );

    for (genvar q = 0; q < int'(NSTEP); q++) begin : g_col
        localparam int unsigned W  = tdec_pkg::step_width(NBITS, q);
        localparam int unsigned WN = W / 2;

        logic [W-1:0]     scale_in;
        logic [NBITS-1:0] bits_in;
        logic             vld_in;
        logic             dbit;
        logic [WN-1:0]    sub;
        logic [NBITS-1:0] bits_cur;
        logic [WN-1:0]    scale_nx;
        logic [NBITS-1:0] bits_nx;
        logic             vld_nx;

        if (q == 0) begin : g_src
            assign scale_in = sync_d;
            assign bits_in  = '0;
            assign vld_in   = sync_v;
        end else begin : g_chain
            assign scale_in = g_col[q-1].scale_nx;
            assign bits_in  = g_col[q-1].bits_nx;
            assign vld_in   = g_col[q-1].vld_nx;
        end

        tdec_column #(
            .W (W)
        ) u_col (
            .scale_i (scale_in),
            .bit_o   (dbit),
            .sub_o   (sub)
        );

        always_comb begin
            bits_cur = bits_in;
            bits_cur[NBITS-1-q] = dbit;
        end

        if (COL_MODE == tdec_pkg::COL_REG && q < int'(NSTEP) - 1) begin : g_reg
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    scale_nx <= '0;
                    bits_nx  <= '0;
                    vld_nx   <= 1'b0;
                end else begin
                    scale_nx <= sub;
                    bits_nx  <= bits_cur;
                    vld_nx   <= vld_in;
                end
            end
        end else begin : g_pass
            assign scale_nx = sub;
            assign bits_nx  = bits_cur;
            assign vld_nx   = vld_in;
        end
    end

    logic [NBITS-1:0] fin_word;

    always_comb begin
        fin_word    = g_col[NSTEP-1].bits_nx;
        fin_word[0] = g_col[NSTEP-1].scale_nx[0];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bin_o     <= '0;
            bin_vld_o <= 1'b0;
        end else begin
            bin_vld_o <= g_col[NSTEP-1].vld_nx;
            if (g_col[NSTEP-1].vld_nx) begin
                bin_o <= fin_word;
            end
        end
    end

    // R6
    hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bin_vld_o && !$past(rst_i)) |-> $stable(bin_o));

endmodule

// File: tb/therm_mux_decoder_bench.sv
module therm_mux_decoder_bench;

    localparam int NB    = 6;
    localparam int LV    = 63;
    localparam int LAT_A = 2 + 4 + 1;
    localparam int LAT_B = 1 + 1;
    localparam int MAXS  = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LV-1:0] therm = '0;
    logic          vld = 1'b0;
    logic [NB-1:0] bin_a, bin_b;
    logic          bv_a, bv_b;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int nsent = 0;
    int rx_a = 0;
    int rx_b = 0;
    logic          seen_a = 1'b0;
    logic          seen_b = 1'b0;
    logic [NB-1:0] last_a = '0;
    logic [NB-1:0] last_b = '0;

    logic [LV-1:0] s_in  [MAXS];
    logic [NB-1:0] s_exp [MAXS];
    int            s_drv [MAXS];
    logic          s_mono[MAXS];
    logic [NB-1:0] got_a [MAXS];
    logic [NB-1:0] got_b [MAXS];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    therm_mux_decoder #(.NBITS(NB), .SYNC_DEPTH(2), .COL_MODE(tdec_pkg::COL_REG)) u_therm_mux_decoder (
        .clk_i(clk), .rst_i(rst), .therm_i(therm), .therm_vld_i(vld),
        .bin_o(bin_a), .bin_vld_o(bv_a));

    therm_mux_decoder #(.NBITS(NB), .SYNC_DEPTH(1), .COL_MODE(tdec_pkg::COL_COMB)) u_therm_mux_decoder_flat (
        .clk_i(clk), .rst_i(rst), .therm_i(therm), .therm_vld_i(vld),
        .bin_o(bin_b), .bin_vld_o(bv_b));

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic logic [NB-1:0] halving_ref(input logic [LV-1:0] t);
        logic [63:0]   s;
        logic [NB-1:0] r;
        int            w;
        s = {1'b0, t};
        w = LV;
        for (int b = NB - 1; b >= 0; b--) begin
            int mid;
            mid = w / 2;
            r[b] = s[mid];
            if (r[b]) s = s >> (mid + 1);
            s = s & ((64'd1 << mid) - 64'd1);
            w = mid;
        end
        return r;
    endfunction

    function automatic logic [LV-1:0] mono(input int k);
        return LV'((64'd1 << k) - 64'd1);
    endfunction

    task automatic send(input logic [LV-1:0] t);
        @(posedge clk);
        #1;
        therm = t;
        vld = 1'b1;
        s_in[nsent]  = t;
        s_drv[nsent] = cyc;
        s_mono[nsent] = (((t + 1'b1) & t) == '0);
        s_exp[nsent] = s_mono[nsent] ? NB'($countones(t)) : halving_ref(t);
        nsent++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            vld = 1'b0;
            therm = {$urandom, $urandom};
        end
    endtask

    task automatic observe(input logic bv, input logic [NB-1:0] b, input int lat,
                           input string tag, inout int rx, inout logic seen,
                           inout logic [NB-1:0] last, input bit is_a);
        if (bv) begin
            if (rx >= nsent) begin
                chk(1'b0, {"R5 ", tag, " unexpected valid"}, rx, nsent);
            end else begin
                if (s_mono[rx])
                    chk(b == s_exp[rx], {"R2 ", tag}, b, s_exp[rx]);
                else
                    chk(b == s_exp[rx], {"R4 ", tag}, b, s_exp[rx]);
                chk(b[NB-1] == s_in[rx][31], {"R3 ", tag}, b[NB-1], s_in[rx][31]);
                chk(cyc == s_drv[rx] + lat, {"R5 ", tag, " latency"}, cyc - s_drv[rx], lat);
                if (is_a) got_a[rx] = b; else got_b[rx] = b;
            end
            rx++;
            seen = 1'b1;
            last = b;
        end else if (seen) begin
            chk(b == last, {"R6 ", tag, " hold"}, b, last);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            observe(bv_a, bin_a, LAT_A, "pipe", rx_a, seen_a, last_a, 1'b1);
            observe(bv_b, bin_b, LAT_B, "flat", rx_b, seen_b, last_b, 1'b0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired rx_a=%0d rx_b=%0d sent=%0d", rx_a, rx_b, nsent);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bv_a == 1'b0 && bin_a == '0, "R1 pipe in reset", {bv_a, bin_a}, 0);
        chk(bv_b == 1'b0 && bin_b == '0, "R1 flat in reset", {bv_b, bin_b}, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(bv_a == 1'b0 && bin_a == '0, "R1 pipe after reset", {bv_a, bin_a}, 0);
        chk(bv_b == 1'b0 && bin_b == '0, "R1 flat after reset", {bv_b, bin_b}, 0);

        // R2, R7: every monotonic code, back to back, rising then falling
        for (int k = 0; k <= LV; k++) send(mono(k));
        for (int k = LV; k >= 0; k--) send(mono(k));
        idle(4);

        // R2, R6: monotonic codes with gaps and scrambled invalid input
        for (int k = 0; k <= LV; k += 3) begin
            send(mono(k));
            idle(1 + (k % 4));
        end

        // R4: single-bubble words
        for (int k = 2; k < LV; k += 5) begin
            logic [LV-1:0] t;
            t = mono(k);
            t[k / 2] = 1'b0;
            send(t);
            idle(1);
        end

        // R3, R4: arbitrary words
        for (int i = 0; i < 120; i++) begin
            send({$urandom, $urandom});
            if (i % 3 == 0) idle(2);
        end
        idle(LAT_A + 6);

        // R7: every sample came out of both variants
        chk(rx_a == nsent, "R7 pipe count", rx_a, nsent);
        chk(rx_b == nsent, "R7 flat count", rx_b, nsent);
        // R8: variants agree sample by sample
        for (int i = 0; i < nsent; i++)
            chk(got_a[i] == got_b[i], "R8 variant match", got_a[i], got_b[i]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule